// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler

This block derives four synchronous clock domains from one main clock and gates individual module clocks inside each domain. The domains are the CPU domain, the high-speed bus (HSB) domain, and two peripheral-bus domains, PBA and PBB. HSB sits under CPU, and both peripheral buses sit under HSB. The main clock comes from either an oscillator input or a PLL input. The prescaler does not generate clocks. It produces single-cycle clock-enable strobes in the fast system clock: one per domain, plus one gated enable per module. This keeps the whole design synchronous and synthesizable.

Both sources arrive as tick strobes. `osc_tick` and `pll_tick` mark a main-clock period of the oscillator or the PLL, sampled in `clk`. A free-running main counter advances on every selected main tick. Each domain divides the main rate by a power of two. Divider settings are checked against the parent/child frequency ordering when they are written. Accepted settings are held pending, and they take effect only when the main counter wraps. At that point every domain is at a shared boundary, so the strobes stay phase-aligned.

Configuration uses a small word-wide write/read port with a combinational read path.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset all dividers are disabled (pending and active settings read 0), the source select and error flag read 0, every mask bit reads 1, and `dom_tick` and `mod_en` are 0.
- R2: The control word at address 0 holds the source select in bit 0: 1 counts `pll_tick` as the main tick, 0 counts `osc_tick`. The other input is ignored.
- R3: A domain whose divide-enable bit is 0 pulses its `dom_tick` bit in the cycle after every main tick.
- R4: A domain whose divide-enable bit is 1, with select value S, pulses once every 2^(S+1) main ticks. The pulse comes in the cycle after each main tick on which the low S+1 bits of the main counter are all ones. The main counter is 2^SEL_W bits wide, counts main ticks from 0 after reset, and wraps to 0.
- R5: A divider write (address 1) is rejected when the effective shifts break the order shift(CPU) ≤ shift(HSB) ≤ shift(PBA) and shift(HSB) ≤ shift(PBB). The effective shift is S+1 when the divide-enable bit is set and 0 otherwise. A rejected write leaves the pending setting unchanged and sets the error flag, which is bit 1 of the control word.
- R6: Writing the control word with bit 1 set clears the error flag. Writing it with bit 1 clear leaves the flag as it is.
- R7: An accepted divider write shows up at once in the pending setting (read at address 1). It becomes active (read at address 2) only on the main tick at which the main counter is all ones, and domain strobes use the new setting from the next main tick onward.
- R8: The module enable `mod_en[32*d+i]` equals `dom_tick[d]` AND bit i of the mask of domain d. That mask is at address 4+d, and a mask write affects `mod_en` from the following cycle.
- R9: A child strobe never fires without its parent: HSB implies CPU, and PBA or PBB implies HSB.
- R10: The divider word packs one 4-bit field per domain: CPU in bits 3:0, HSB in 7:4, PBA in 11:8 and PBB in 15:12. In each field, bit 3 is divide-enable and bits 2:0 are the select value S. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any main tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator main-clock strobe |
| pll_tick | input | 1 | PLL main-clock strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dom_tick | output | 4 | Domain strobes: bit 0 CPU, 1 HSB, 2 PBA, 3 PBB |
| mod_en | output | 128 | Per-module gated enables, 32 per domain |

## Verification
The main function is exercised with several main-tick patterns:
- A steady tick on every cycle shows the exact division cadence against the counter phase.
- A sparse and irregular tick shows that division counts main ticks and not system cycles.
- Toggling the source select while the two inputs differ shows which input is actually counted.

A behavioural model predicts every strobe and enable on every cycle. Directed writes cover the following cases:
- A legal mixed-divider setting.
- A setting with CPU slower than HSB and one with PBB faster than HSB, both of which must be refused.
- A setting applied mid-period, which must wait for the counter wrap.
- Mask patterns that separate single-bit gating from whole-domain gating.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam int BCP_NDOM  = 4;
  localparam int BCP_SEL_W = 3;
  localparam int BCP_MOD_W = 32;

  typedef enum int {
    DOM_CPU = 0,
    DOM_HSB = 1,
    DOM_PBA = 2,
    DOM_PBB = 3
  } dom_e;

  typedef enum logic [2:0] {
    RA_CTRL     = 3'd0,
    RA_DIV_PEND = 3'd1,
    RA_DIV_ACT  = 3'd2
  } reg_addr_e;
endpackage

// File: rtl/bcp_tick_src.sv
module bcp_tick_src #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pll,
  input  logic             osc_tick,
  input  logic             pll_tick,
  output logic             main_tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    main_tick = src_pll ? pll_tick : osc_tick;
    cnt_d     = cnt_q;
    if (main_tick) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = main_tick && (&cnt_q);

  // R4: the counter only moves on a main tick
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !main_tick |=> $stable(cnt_q));
endmodule

// File: rtl/bcp_regs.sv
module bcp_regs #(
  parameter int NDOM   = 4,
  parameter int SEL_W  = 3,
  parameter int MOD_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [2:0]              addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    apply,
  output logic [DATA_W-1:0]       rdata,
  output logic                    src_pll,
  output logic [NDOM*(SEL_W+1)-1:0] act_cfg,
  output logic [NDOM*MOD_W-1:0]   masks
);
  import bcp_pkg::*;

  localparam int FLD_W = SEL_W + 1;
  localparam int CFG_W = NDOM * FLD_W;
  localparam int SH_W  = $clog2((1 << SEL_W) + 1);

  logic             src_q, src_d;
  logic             flag_q, flag_d;
  logic [CFG_W-1:0] pend_q, pend_d;
  logic [CFG_W-1:0] act_q, act_d;
  logic [NDOM*MOD_W-1:0] mask_q, mask_d;
  logic             div_wr, bad_wr;

  function automatic logic [SH_W-1:0] fld_shift(input logic [FLD_W-1:0] f);
    return f[SEL_W] ? (SH_W'(f[SEL_W-1:0]) + SH_W'(1)) : '0;
  endfunction

  function automatic logic cfg_legal(input logic [CFG_W-1:0] c);
    logic [SH_W-1:0] s_cpu, s_hsb, s_pba, s_pbb;
    s_cpu = fld_shift(c[DOM_CPU*FLD_W +: FLD_W]);
    s_hsb = fld_shift(c[DOM_HSB*FLD_W +: FLD_W]);
    s_pba = fld_shift(c[DOM_PBA*FLD_W +: FLD_W]);
    s_pbb = fld_shift(c[DOM_PBB*FLD_W +: FLD_W]);
    return (s_cpu <= s_hsb) && (s_hsb <= s_pba) && (s_hsb <= s_pbb);
  endfunction

  assign div_wr = we && (addr == RA_DIV_PEND);
  assign bad_wr = div_wr && !cfg_legal(wdata[CFG_W-1:0]);

  always_comb begin
    src_d  = src_q;
    flag_d = flag_q;
    pend_d = pend_q;
    act_d  = apply ? pend_q : act_q;
    mask_d = mask_q;
    if (we) begin
      if (addr == RA_CTRL) begin
        src_d = wdata[0];
        if (wdata[1]) flag_d = 1'b0;
      end else if (addr == RA_DIV_PEND) begin
        if (bad_wr) flag_d = 1'b1;
        else        pend_d = wdata[CFG_W-1:0];
      end else if (addr[2]) begin
        mask_d[addr[1:0]*MOD_W +: MOD_W] = wdata[MOD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= '0;
      act_q  <= '0;
      mask_q <= '1;
    end else begin
      src_q  <= src_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_CTRL) begin
      rdata[0] = src_q;
      rdata[1] = flag_q;
    end else if (addr == RA_DIV_PEND) begin
      rdata[CFG_W-1:0] = pend_q;
    end else if (addr == RA_DIV_ACT) begin
      rdata[CFG_W-1:0] = act_q;
    end else if (addr[2]) begin
      rdata[MOD_W-1:0] = mask_q[addr[1:0]*MOD_W +: MOD_W];
    end
  end

  assign src_pll = src_q;
  assign act_cfg = act_q;
  assign masks   = mask_q;

  // R5: the active setting never breaks the ordering
  p_act_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(act_q));
  // R5: the flag only rises after a refused divider write
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(bad_wr));
  // R7: the active setting moves only at the shared boundary
  p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act_q));
  // R5: a refused write leaves the pending setting alone
  p_pend_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(pend_q));
endmodule

// File: rtl/bcp_dom_gate.sv
module bcp_dom_gate #(
  parameter int SEL_W = 3,
  parameter int MOD_W = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W:0]   cfg,
  input  logic [MOD_W-1:0] mask,
  output logic             tick,
  output logic [MOD_W-1:0] en
);
  localparam int SH_W = $clog2(CNT_W + 1);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] low;
  logic             hit;
  logic             tick_q, tick_d;
  logic [MOD_W-1:0] en_q, en_d;

  always_comb begin
    sh = cfg[SEL_W] ? (SH_W'(cfg[SEL_W-1:0]) + SH_W'(1)) : '0;
    for (int b = 0; b < CNT_W; b++) low[b] = (SH_W'(b) < sh);
    hit    = main_tick && ((cnt & low) == low);
    tick_d = hit;
    en_d   = hit ? mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      en_q   <= '0;
    end else begin
      tick_q <= tick_d;
      en_q   <= en_d;
    end
  end

  assign tick = tick_q;
  assign en   = en_q;

  // R8: no module enable without its domain strobe
  p_en_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_q) |-> tick_q);
  // R3: a strobe always follows a main tick
  p_tick_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(main_tick));
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
  import bcp_pkg::*;
#(
  parameter int SEL_W  = BCP_SEL_W,
  parameter int MOD_W  = BCP_MOD_W,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_tick,
  input  logic                     pll_tick,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [BCP_NDOM-1:0]      dom_tick,
  output logic [BCP_NDOM*MOD_W-1:0] mod_en
);
  localparam int NDOM  = BCP_NDOM;
  localparam int FLD_W = SEL_W + 1;
  localparam int CNT_W = 1 << SEL_W;

  logic rs1_q, rs2_q, rst_int_n;
  logic src_pll, main_tick, wrap;
  logic [CNT_W-1:0] cnt;
  logic [NDOM*FLD_W-1:0] act_cfg;
  logic [NDOM*MOD_W-1:0] masks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  bcp_tick_src #(.CNT_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_int_n), .src_pll(src_pll),
    .osc_tick(osc_tick), .pll_tick(pll_tick),
    .main_tick(main_tick), .cnt(cnt), .wrap(wrap)
  );

  bcp_regs #(.NDOM(NDOM), .SEL_W(SEL_W), .MOD_W(MOD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .apply(wrap), .rdata(reg_rdata),
    .src_pll(src_pll), .act_cfg(act_cfg), .masks(masks)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    bcp_dom_gate #(.SEL_W(SEL_W), .MOD_W(MOD_W), .CNT_W(CNT_W)) u_gate (
      .clk(clk), .rst_n(rst_int_n), .main_tick(main_tick), .cnt(cnt),
      .cfg(act_cfg[d*FLD_W +: FLD_W]), .mask(masks[d*MOD_W +: MOD_W]),
      .tick(dom_tick[d]), .en(mod_en[d*MOD_W +: MOD_W])
    );
  end

  // R9: child strobes nest inside parent strobes
  p_hsb_in_cpu_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    dom_tick[DOM_HSB] |-> dom_tick[DOM_CPU]);
  p_pba_in_hsb_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    dom_tick[DOM_PBA] |-> dom_tick[DOM_HSB]);
  p_pbb_in_hsb_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    dom_tick[DOM_PBB] |-> dom_tick[DOM_HSB]);
endmodule

// File: tb/bus_clk_prescaler_bench.sv
module bus_clk_prescaler_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, osc_tick, pll_tick, reg_we;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic [3:0]   dom_tick;
  logic [127:0] mod_en;

  bus_clk_prescaler u_bus_clk_prescaler (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dom_tick(dom_tick), .mod_en(mod_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int osc_mode = 0;
  int pll_mode = 2;
  int cyc = 0;

  // behavioural model
  bit rs1, rs2;
  int m_cnt;
  bit m_src, m_flag;
  bit [15:0] m_pend, m_act;
  bit [31:0] m_mask [4];
  bit [3:0] m_tick;
  bit [127:0] m_en;

  function automatic int shf(bit [3:0] f);
    return f[3] ? int'(f[2:0]) + 1 : 0;
  endfunction

  function automatic bit legal(bit [15:0] c);
    return shf(c[3:0]) <= shf(c[7:4]) && shf(c[7:4]) <= shf(c[11:8]) &&
           shf(c[7:4]) <= shf(c[15:12]);
  endfunction

  function automatic bit [31:0] exp_rd(bit [2:0] a);
    if (a == 0) return {30'b0, m_flag, m_src};
    if (a == 1) return {16'b0, m_pend};
    if (a == 2) return {16'b0, m_act};
    if (a[2])   return m_mask[a[1:0]];
    return 32'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit mt;
    bit [3:0] nt;
    bit [127:0] ne;
    bit [15:0] na;
    if (!rst_n) begin
      rs1 = 0; rs2 = 0;
    end else begin
      if (!rs2) begin
        m_cnt = 0; m_src = 0; m_flag = 0; m_pend = 0; m_act = 0;
        m_tick = 0; m_en = 0;
        for (int d = 0; d < 4; d++) m_mask[d] = '1;
      end else begin
        mt = m_src ? pll_tick : osc_tick;
        for (int d = 0; d < 4; d++) begin
          int p;
          p = 1 << shf(m_act[4*d +: 4]);
          nt[d] = mt && ((m_cnt % p) == p - 1);
          for (int i = 0; i < 32; i++) ne[32*d+i] = nt[d] & m_mask[d][i];
        end
        na = (mt && m_cnt == 255) ? m_pend : m_act;
        if (mt) m_cnt = (m_cnt + 1) % 256;
        if (reg_we) begin
          if (reg_addr == 0) begin
            m_src = reg_wdata[0];
            if (reg_wdata[1]) m_flag = 0;
          end else if (reg_addr == 1) begin
            if (legal(reg_wdata[15:0])) m_pend = reg_wdata[15:0];
            else m_flag = 1;
          end else if (reg_addr[2]) m_mask[reg_addr[1:0]] = reg_wdata;
        end
        m_act = na; m_tick = nt; m_en = ne;
      end
      rs2 = rs1; rs1 = 1;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // tick pattern generator
  always @(negedge clk) begin
    cyc++;
    case (osc_mode)
      0: osc_tick <= 1'b1;
      1: osc_tick <= 1'($urandom_range(0, 1));
      default: osc_tick <= 1'b0;
    endcase
    case (pll_mode)
      0: pll_tick <= 1'b1;
      1: pll_tick <= (cyc % 3 == 0);
      default: pll_tick <= 1'b0;
    endcase
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && rs2 && !done) begin
      chk("R4 domain strobes (R3 when undivided)", 128'(dom_tick), 128'(m_tick));
      chk("R8 module enables", mod_en, m_en);
      chk("R10 register readback", 128'(reg_rdata), 128'(exp_rd(reg_addr)));
      chk("R9 child without parent", 128'((dom_tick[1] & ~dom_tick[0]) |
          (dom_tick[2] & ~dom_tick[1]) | (dom_tick[3] & ~dom_tick[1])), 128'(0));
    end
  end

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(bit [2:0] a, bit [31:0] e, string req);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(req, 128'(reg_rdata), 128'(e));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    osc_tick = 0; pll_tick = 0;
    idle(3);
    #1;
    chk("R1 strobes in reset", 128'(dom_tick), 128'(0));
    chk("R1 enables in reset", mod_en, 128'(0));
    @(negedge clk);
    rst_n = 1;
    idle(4);
    rd(0, 32'h0, "R1 control after reset");
    rd(1, 32'h0, "R1 pending after reset");
    rd(2, 32'h0, "R1 active after reset");
    for (int d = 0; d < 4; d++) rd(3'(4 + d), 32'hFFFF_FFFF, "R1 masks after reset");
    rd(3, 32'h0, "R10 unused address");

    // R3: undivided, osc ticks every cycle
    idle(3); #2;
    chk("R3 all domains every tick", 128'(dom_tick), 128'(4'hF));

    // R2: select PLL while the PLL is silent, then active
    wr(0, 32'h1);
    idle(4); #2;
    chk("R2 silent PLL ignores oscillator", 128'(dom_tick), 128'(0));
    pll_mode = 0;
    idle(4); #2;
    chk("R2 PLL ticks counted", 128'(dom_tick), 128'(4'hF));
    pll_mode = 1;
    idle(40);
    wr(0, 32'h0);

    // R7: legal setting waits for the wrap
    wr(1, 32'h0000_FA98);
    rd(1, 32'h0000_FA98, "R7 pending visible at once");
    rd(2, 32'h0, "R7 active not yet changed");
    idle(300);
    rd(2, 32'h0000_FA98, "R7 active after wrap");

    // R5: CPU slower than HSB is refused
    wr(1, 32'h0000_008A);
    rd(1, 32'h0000_FA98, "R5 pending unchanged on refusal");
    rd(0, 32'h2, "R5 flag set");
    wr(0, 32'h0);
    rd(0, 32'h2, "R6 flag kept without clear bit");
    wr(0, 32'h2);
    rd(0, 32'h0, "R6 flag cleared");
    // R5: PBB faster than HSB is refused
    wr(1, 32'h0000_9BA8);
    rd(0, 32'h2, "R5 flag set for PBB order");
    wr(0, 32'h2);

    // R8 masks with irregular ticks
    wr(4, 32'hA5A5_A5A5);
    wr(5, 32'h0000_FFFF);
    wr(6, 32'h8000_0001);
    wr(7, 32'h0);
    osc_mode = 1;
    idle(1200);
    wr(1, 32'h0000_CBA8);
    wr(0, 32'h1);
    idle(1500);
    wr(0, 32'h0);
    wr(7, 32'hFFFF_FFFF);
    idle(900);
    wr(1, 32'h0);
    osc_mode = 0;
    idle(600);
    rd(2, 32'h0, "R7 dividers off again");
    finish_run();
  end
endmodule